// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers of a processor core with several privilege modes, together with the current status word and the saved status words of the exception banks. Some register numbers have a private physical copy per bank. Changing the 5-bit mode input selects which copies the register numbers reach, so a mode switch exchanges the registers without any copying cycles.

The core reads through two ports and writes through one, all addressed by register number and all resolved against the current bank. A separate debug port names both a mode and a register. It can read or write the copy belonging to any bank, including the bank in use. A status write path updates the current or the saved status word byte by byte under a 4-bit lane mask. In the user bank, that path may change only the flag byte of the current status word.

The mode input is registered once, and the read ports follow the registered mode. Writes issued in the cycle the mode input changes are steered by the incoming mode.

Top module: `banked_regfile`

## Requirements
- R1: The mode decodes to a bank reported on `bank_o` with codes user=0, fast-interrupt=1, interrupt=2, supervisor=3, abort=4, undefined=5, dummy=6. Modes 0 and 16 give user, 1 and 17 give fast-interrupt, 2 and 18 give interrupt, 3 and 19 give supervisor, 23 gives abort, 27 gives undefined, 31 (system) gives user, and every other value gives dummy. `bank_o` follows `mode_i` one clock edge later.
- R2: Registers 0 to 7 and 15 are one physical copy that every bank reads and writes.
- R3: The fast-interrupt bank has private registers 8 to 14. Writes made to them leave the user copies unchanged.
- R4: The interrupt, supervisor, abort and undefined banks have private registers 13 and 14 and reach the user copies of registers 8 to 12. System mode reaches the user registers throughout.
- R5: The dummy bank has private registers 8 to 14. These are cleared on every edge where the bank moves into or out of dummy, so they read zero on entry and read zero through the debug port once left.
- R6: A core write, debug write or status write in the cycle that `mode_i` changes goes to the bank of the new mode. The read ports use the registered mode.
- R7: The debug port reads combinationally, and on a clock edge writes, the copy of `dbg_reg` that belongs to the bank of `dbg_mode`. When it writes the same physical register as the core write port in the same cycle, the core write wins.
- R8: Saved status words exist only for banks 1 to 5. For any other bank, `st_saved_o` shows the current status word and saved-status writes are ignored.
- R9: Mask bit k of `st_mask` enables byte lane k of the target word (bit 0 = bits 7:0, bit 1 = 15:8, bit 2 = 23:16, bit 3 = 31:24). `st_saved` = 1 targets the saved word of the bank, and 0 targets the current word.
- R10: In the user bank, a current-status write changes only bits 31:24, whatever the mask.
- R11: After reset the file is in supervisor mode (`bank_o` = 3), and every register copy and every status word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Requested processor mode |
| bank_o | output | 3 | Bank of the registered mode |
| ra_addr | input | 4 | Read port A register number |
| ra_data | output | 32 | Read port A data |
| rb_addr | input | 4 | Read port B register number |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | Core write enable |
| wr_addr | input | 4 | Core write register number |
| wr_data | input | 32 | Core write data |
| dbg_mode | input | 5 | Mode whose copy the debug port addresses |
| dbg_reg | input | 4 | Debug register number |
| dbg_we | input | 1 | Debug write enable |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data |
| st_we | input | 1 | Status write enable |
| st_saved | input | 1 | 1 = saved status word, 0 = current status word |
| st_mask | input | 4 | Byte lane mask for status writes |
| st_wdata | input | 32 | Status write data |
| st_cur_o | output | 32 | Current status word |
| st_saved_o | output | 32 | Saved status word of the current bank, or the current word |

## Verification
The bench moves between every bank kind and checks which copies are shared and which are private. A design that swapped registers 8 to 12 for an ordinary exception bank would lose the user value of register 8 in the interrupt bank. A design that let system mode use a bank of its own would hide the user stack register. The bench leaves the dummy bank after writing to it and reads that bank through the debug port, which exposes a design that keeps stale values. It also writes in the same cycle as a mode change, which exposes a design that steers the write into the bank being left. For the status path it checks that writes with only some lanes enabled merge correctly. It also checks that the user bank cannot change the lower three bytes, and that saved-status writes made from the user bank leave the supervisor copy untouched.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

  localparam int NUM_REGS   = 16;
  localparam int RA_W       = $clog2(NUM_REGS);
  localparam int MODE_W     = 5;
  localparam int NUM_BANKS  = 7;
  localparam int MID_LO     = 8;   // first register of the fast-interrupt range
  localparam int MID_HI     = 12;  // last register shared by ordinary exception banks
  localparam int MID_N      = MID_HI - MID_LO + 1;
  localparam int MID_SLOTS  = 3;   // user, fast-interrupt, dummy
  localparam int TOP_LO     = 13;
  localparam int TOP_N      = 2;
  localparam int COMMON_N   = MID_LO + 1;  // r0..r7 plus r15
  localparam int MID_BASE   = COMMON_N;
  localparam int TOP_BASE   = MID_BASE + MID_SLOTS * MID_N;
  localparam int NPHYS      = TOP_BASE + NUM_BANKS * TOP_N;
  localparam int IDX_W      = $clog2(NPHYS);
  localparam int NSAVED     = 5;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5,
    BK_DUM = 3'd6
  } bank_e;

  function automatic bank_e mode_to_bank(input logic [MODE_W-1:0] m);
    case (m)
      5'd0, 5'd16, 5'd31: mode_to_bank = BK_USR;
      5'd1, 5'd17:        mode_to_bank = BK_FIQ;
      5'd2, 5'd18:        mode_to_bank = BK_IRQ;
      5'd3, 5'd19:        mode_to_bank = BK_SVC;
      5'd23:              mode_to_bank = BK_ABT;
      5'd27:              mode_to_bank = BK_UND;
      default:            mode_to_bank = BK_DUM;
    endcase
  endfunction

  function automatic logic bank_has_saved(input bank_e b);
    bank_has_saved = (b != BK_USR) && (b != BK_DUM);
  endfunction

  // Physical storage index of register r as seen from bank b.
  function automatic logic [IDX_W-1:0] phys_idx(input bank_e b, input logic [RA_W-1:0] r);
    int ri;
    int slot;
    int res;
    ri = int'(r);
    if (ri < MID_LO) begin
      res = ri;
    end else if (ri == NUM_REGS - 1) begin
      res = MID_LO;
    end else if (ri <= MID_HI) begin
      slot = (b == BK_FIQ) ? 1 : ((b == BK_DUM) ? 2 : 0);
      res  = MID_BASE + slot * MID_N + (ri - MID_LO);
    end else begin
      res = TOP_BASE + int'(b) * TOP_N + (ri - TOP_LO);
    end
    phys_idx = IDX_W'(res);
  endfunction

endpackage

// File: rtl/rbf_mode_map.sv
module rbf_mode_map
  import rbf_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output bank_e             bank
);
  assign bank = mode_to_bank(mode);
endmodule

// File: rtl/rbf_gpr_store.sv
module rbf_gpr_store
  import rbf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             cur_bank,
  input  bank_e             eff_bank,
  input  bank_e             dbg_bank,
  input  logic [RA_W-1:0]   ra_addr,
  output logic [XLEN-1:0]   ra_data,
  input  logic [RA_W-1:0]   rb_addr,
  output logic [XLEN-1:0]   rb_data,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   wr_addr,
  input  logic [XLEN-1:0]   wr_data,
  input  logic [RA_W-1:0]   dbg_reg,
  input  logic              dbg_we,
  input  logic [XLEN-1:0]   dbg_wdata,
  output logic [XLEN-1:0]   dbg_rdata
);

  logic [NPHYS-1:0][XLEN-1:0] mem_q, mem_d;
  logic [IDX_W-1:0] ra_idx, rb_idx, wr_idx, dbg_idx;
  logic             dum_swap;
  logic             mem_en;

  assign ra_idx  = phys_idx(cur_bank, ra_addr);
  assign rb_idx  = phys_idx(cur_bank, rb_addr);
  assign wr_idx  = phys_idx(eff_bank, wr_addr);
  assign dbg_idx = phys_idx(dbg_bank, dbg_reg);

  // Moving into or out of the dummy bank wipes its private copies.
  assign dum_swap = (eff_bank == BK_DUM) != (cur_bank == BK_DUM);
  assign mem_en   = dum_swap | wr_en | dbg_we;

  always_comb begin
    mem_d = mem_q;
    if (dum_swap) begin
      for (int r = MID_LO; r < TOP_LO + TOP_N; r++) begin
        mem_d[phys_idx(BK_DUM, RA_W'(r))] = '0;
      end
    end
    if (dbg_we) mem_d[dbg_idx] = dbg_wdata;
    if (wr_en)  mem_d[wr_idx]  = wr_data;  // core port has last word
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mem_q <= '0;
    else if (mem_en) mem_q <= mem_d;
  end

  assign ra_data   = mem_q[ra_idx];
  assign rb_data   = mem_q[rb_idx];
  assign dbg_rdata = mem_q[dbg_idx];

  // R3 / R6: a core write is found in the addressed copy one edge later
  a_r6_core_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_idx)] == $past(wr_data));

  // R7: a debug write lands unless the core port hit the same copy
  a_r7_debug_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_we && !(wr_en && wr_idx == dbg_idx)) |=> mem_q[$past(dbg_idx)] == $past(dbg_wdata));

  // R5: first cycle in the dummy bank reads zero for r8..r14 if nothing was written
  a_r5_dummy_entry_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_bank == BK_DUM && $past(cur_bank) != BK_DUM && !$past(wr_en) && !$past(dbg_we)
     && ra_addr >= RA_W'(MID_LO) && ra_addr <= RA_W'(TOP_LO + TOP_N - 1)) |-> ra_data == '0);

endmodule

// File: rtl/rbf_status.sv
module rbf_status
  import rbf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             cur_bank,
  input  bank_e             eff_bank,
  input  logic              st_we,
  input  logic              st_saved,
  input  logic [XLEN/8-1:0] st_mask,
  input  logic [XLEN-1:0]   st_wdata,
  output logic [XLEN-1:0]   st_cur_o,
  output logic [XLEN-1:0]   st_saved_o
);

  localparam int LANES  = XLEN / 8;
  localparam int SLOT_W = $clog2(NSAVED);

  logic [XLEN-1:0]              cur_q, cur_d;
  logic [NSAVED-1:0][XLEN-1:0]  sav_q, sav_d;
  logic [XLEN-1:0]              sav_merge;
  logic [LANES-1:0]             cur_lane_we;
  logic                         cur_en, sav_en;
  logic [SLOT_W-1:0]            wr_slot, rd_slot;

  assign wr_slot = SLOT_W'(int'(eff_bank) - 1);
  assign rd_slot = SLOT_W'(int'(cur_bank) - 1);
  assign sav_en  = st_we & st_saved & bank_has_saved(eff_bank);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    // Outside the user bank every lane is writable; inside it only the top one.
    if (k == LANES - 1) begin : g_flag
      assign cur_lane_we[k] = st_we & ~st_saved & st_mask[k];
    end else begin : g_ctl
      assign cur_lane_we[k] = st_we & ~st_saved & st_mask[k] & (eff_bank != BK_USR);
    end
    assign cur_d[k*8 +: 8]     = cur_lane_we[k] ? st_wdata[k*8 +: 8] : cur_q[k*8 +: 8];
    assign sav_merge[k*8 +: 8] = st_mask[k] ? st_wdata[k*8 +: 8] : sav_q[wr_slot][k*8 +: 8];
  end

  assign cur_en = |cur_lane_we;

  always_comb begin
    sav_d = sav_q;
    sav_d[wr_slot] = sav_merge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sav_q <= '0;
    else if (sav_en) sav_q <= sav_d;
  end

  assign st_cur_o   = cur_q;
  assign st_saved_o = bank_has_saved(cur_bank) ? sav_q[rd_slot] : cur_q;

  // R10: user-bank status writes never touch the lower bytes
  a_r10_user_flags_only: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && !st_saved && eff_bank == BK_USR) |=> cur_q[XLEN-9:0] == $past(cur_q[XLEN-9:0]));

  // R8: saved-status writes from a bank without one change nothing
  a_r8_saved_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && st_saved && !bank_has_saved(eff_bank)) |=> $stable(sav_q));

  // R9: an all-zero mask leaves the current word alone
  a_r9_empty_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && st_mask == '0) |=> $stable(cur_q) && $stable(sav_q));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rbf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [4:0]         mode_i,
  output logic [2:0]         bank_o,
  input  logic [3:0]         ra_addr,
  output logic [XLEN-1:0]    ra_data,
  input  logic [3:0]         rb_addr,
  output logic [XLEN-1:0]    rb_data,
  input  logic               wr_en,
  input  logic [3:0]         wr_addr,
  input  logic [XLEN-1:0]    wr_data,
  input  logic [4:0]         dbg_mode,
  input  logic [3:0]         dbg_reg,
  input  logic               dbg_we,
  input  logic [XLEN-1:0]    dbg_wdata,
  output logic [XLEN-1:0]    dbg_rdata,
  input  logic               st_we,
  input  logic               st_saved,
  input  logic [XLEN/8-1:0]  st_mask,
  input  logic [XLEN-1:0]    st_wdata,
  output logic [XLEN-1:0]    st_cur_o,
  output logic [XLEN-1:0]    st_saved_o
);

  localparam logic [MODE_W-1:0] RESET_MODE = 5'd19;

  logic [MODE_W-1:0] mode_q;
  logic              mode_en;
  bank_e             cur_bank, eff_bank, dbg_bank;

  assign mode_en = (mode_i != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= RESET_MODE;
    else if (mode_en) mode_q <= mode_i;
  end

  rbf_mode_map u_map_cur (.mode(mode_q),   .bank(cur_bank));
  rbf_mode_map u_map_eff (.mode(mode_i),   .bank(eff_bank));
  rbf_mode_map u_map_dbg (.mode(dbg_mode), .bank(dbg_bank));

  assign bank_o = cur_bank;

  rbf_gpr_store #(.XLEN(XLEN)) u_gpr (
    .clk(clk), .rst_n(rst_n),
    .cur_bank(cur_bank), .eff_bank(eff_bank), .dbg_bank(dbg_bank),
    .ra_addr(ra_addr), .ra_data(ra_data),
    .rb_addr(rb_addr), .rb_data(rb_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dbg_reg(dbg_reg), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
  );

  rbf_status #(.XLEN(XLEN)) u_status (
    .clk(clk), .rst_n(rst_n),
    .cur_bank(cur_bank), .eff_bank(eff_bank),
    .st_we(st_we), .st_saved(st_saved), .st_mask(st_mask), .st_wdata(st_wdata),
    .st_cur_o(st_cur_o), .st_saved_o(st_saved_o)
  );

  // R1: the reported bank tracks the previous cycle's mode input
  a_r1_bank_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_i) == 5'd17 |-> bank_o == 3'd1);

  // R1: the reported bank never takes the unused code
  a_r1_bank_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
    bank_o != 3'd7);

endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  mode_i;
  logic [2:0]  bank_o;
  logic [3:0]  ra_addr, rb_addr, wr_addr, dbg_reg;
  logic [31:0] ra_data, rb_data, wr_data, dbg_wdata, dbg_rdata;
  logic        wr_en, dbg_we, st_we, st_saved;
  logic [4:0]  dbg_mode;
  logic [3:0]  st_mask;
  logic [31:0] st_wdata, st_cur_o, st_saved_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  banked_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .bank_o(bank_o),
    .ra_addr(ra_addr), .ra_data(ra_data), .rb_addr(rb_addr), .rb_data(rb_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dbg_mode(dbg_mode), .dbg_reg(dbg_reg), .dbg_we(dbg_we),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .st_we(st_we), .st_saved(st_saved), .st_mask(st_mask), .st_wdata(st_wdata),
    .st_cur_o(st_cur_o), .st_saved_o(st_saved_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // {req(4), mode(5), we(1), waddr(4), wdata(32), raddr(4), expect(32)}
  localparam int NV = 17;
  localparam logic [81:0] VEC [NV] = '{
    {4'd3, 5'd16, 1'b1, 4'd8,  32'h0000_00A1, 4'd8,  32'h0000_00A1}, // R3 user r8
    {4'd4, 5'd16, 1'b1, 4'd13, 32'h0000_00B1, 4'd13, 32'h0000_00B1}, // R4 user r13
    {4'd2, 5'd16, 1'b1, 4'd0,  32'h0000_00C0, 4'd0,  32'h0000_00C0}, // R2 r0
    {4'd3, 5'd17, 1'b1, 4'd8,  32'h0000_00F8, 4'd8,  32'h0000_00F8}, // R3 fiq r8
    {4'd3, 5'd17, 1'b0, 4'd0,  32'h0,         4'd13, 32'h0},         // R3 fiq r13 private
    {4'd2, 5'd17, 1'b0, 4'd0,  32'h0,         4'd0,  32'h0000_00C0}, // R2 r0 shared
    {4'd3, 5'd16, 1'b0, 4'd0,  32'h0,         4'd8,  32'h0000_00A1}, // R3 user r8 kept
    {4'd4, 5'd18, 1'b1, 4'd13, 32'h0000_0D13, 4'd13, 32'h0000_0D13}, // R4 irq r13
    {4'd4, 5'd18, 1'b0, 4'd0,  32'h0,         4'd8,  32'h0000_00A1}, // R4 irq sees user r8
    {4'd4, 5'd31, 1'b0, 4'd0,  32'h0,         4'd13, 32'h0000_00B1}, // R4 system = user
    {4'd4, 5'd19, 1'b0, 4'd0,  32'h0,         4'd13, 32'h0},         // R4 svc r13
    {4'd5, 5'd20, 1'b0, 4'd0,  32'h0,         4'd8,  32'h0},         // R5 dummy reads zero
    {4'd5, 5'd20, 1'b1, 4'd9,  32'h0000_00EE, 4'd9,  32'h0000_00EE}, // R5 dummy writable
    {4'd1, 5'd2,  1'b0, 4'd0,  32'h0,         4'd13, 32'h0000_0D13}, // R1 mode 2 = irq
    {4'd4, 5'd23, 1'b1, 4'd14, 32'h0000_00AB, 4'd14, 32'h0000_00AB}, // R4 abort r14
    {4'd4, 5'd27, 1'b0, 4'd0,  32'h0,         4'd14, 32'h0},         // R4 undefined r14
    {4'd3, 5'd17, 1'b0, 4'd0,  32'h0,         4'd8,  32'h0000_00F8}  // R3 fiq r8 kept
  };

  localparam int NM = 10;
  localparam logic [4:0] MODES [NM] = '{5'd0, 5'd1, 5'd3, 5'd16, 5'd23, 5'd27, 5'd31, 5'd20, 5'd5, 5'd30};
  localparam logic [2:0] BANKS [NM] = '{3'd0, 3'd1, 3'd3, 3'd0,  3'd4,  3'd5,  3'd0,  3'd6,  3'd6, 3'd6};

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_i = 5'd19; ra_addr = 4'd13; rb_addr = 4'd0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    dbg_mode = 5'd19; dbg_reg = '0; dbg_we = 1'b0; dbg_wdata = '0;
    st_we = 1'b0; st_saved = 1'b0; st_mask = '0; st_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R11 reset state
    check("R11 bank after reset", 32'(bank_o), 32'd3);
    check("R11 r13 after reset", ra_data, 32'h0);
    check("R11 current status after reset", st_cur_o, 32'h0);
    check("R11 saved status after reset", st_saved_o, 32'h0);

    // Table walk: R2 R3 R4 R5 R1
    for (int i = 0; i < NV; i++) begin
      mode_i  = VEC[i][77:73];
      wr_en   = VEC[i][72];
      wr_addr = VEC[i][71:68];
      wr_data = VEC[i][67:36];
      ra_addr = VEC[i][35:32];
      rb_addr = VEC[i][35:32];
      tick();
      wr_en = 1'b0;
      check($sformatf("R%0d row %0d port A", VEC[i][81:78], i), ra_data, VEC[i][31:0]);
      check($sformatf("R%0d row %0d port B", VEC[i][81:78], i), rb_data, VEC[i][31:0]);
    end

    // R5 dummy copies wiped on exit
    dbg_mode = 5'd20; dbg_reg = 4'd9; #1;
    check("R5 dummy r9 after exit", dbg_rdata, 32'h0);

    // R6 write in the mode-change cycle goes to the new bank
    mode_i = 5'd18; wr_en = 1'b1; wr_addr = 4'd14; wr_data = 32'h0000_0099;
    ra_addr = 4'd14;
    tick();
    wr_en = 1'b0;
    check("R6 irq r14 written at switch", ra_data, 32'h0000_0099);
    dbg_mode = 5'd17; dbg_reg = 4'd14; #1;
    check("R6 fiq r14 untouched", dbg_rdata, 32'h0);

    // R7 debug write into another bank
    dbg_mode = 5'd17; dbg_reg = 4'd10; dbg_we = 1'b1; dbg_wdata = 32'h5A5A_5A5A;
    tick();
    dbg_we = 1'b0; ra_addr = 4'd10; #1;
    check("R7 user r10 not hit by fiq debug write", ra_data, 32'h0);
    check("R7 fiq r10 via debug", dbg_rdata, 32'h5A5A_5A5A);
    dbg_mode = 5'd18; dbg_reg = 4'd13; #1;
    check("R7 debug read of irq r13", dbg_rdata, 32'h0000_0D13);

    // R7 collision: core write wins
    wr_en = 1'b1; wr_addr = 4'd13; wr_data = 32'h0000_1111;
    dbg_we = 1'b1; dbg_mode = 5'd18; dbg_reg = 4'd13; dbg_wdata = 32'h0000_2222;
    ra_addr = 4'd13;
    tick();
    wr_en = 1'b0; dbg_we = 1'b0;
    check("R7 collision core wins", ra_data, 32'h0000_1111);
    check("R7 debug on current mode is live", dbg_rdata, 32'h0000_1111);

    // R2 r15 shared
    wr_en = 1'b1; wr_addr = 4'd15; wr_data = 32'h0000_0F15;
    tick();
    wr_en = 1'b0; dbg_mode = 5'd17; dbg_reg = 4'd15; #1;
    check("R2 r15 shared with fiq", dbg_rdata, 32'h0000_0F15);

    // Status path: R9 R8 R10
    mode_i = 5'd19; tick();
    st_we = 1'b1; st_saved = 1'b0; st_mask = 4'b0101; st_wdata = 32'h1122_3344;
    tick();
    check("R9 current masked write", st_cur_o, 32'h0022_0044);
    st_saved = 1'b1; st_mask = 4'b1111; st_wdata = 32'hCAFE_F00D;
    tick();
    check("R8 svc saved write", st_saved_o, 32'hCAFE_F00D);
    st_mask = 4'b0010; st_wdata = 32'h0000_AB00;
    tick();
    st_we = 1'b0;
    check("R9 saved lane 1 only", st_saved_o, 32'hCAFE_AB0D);
    mode_i = 5'd16; tick();
    check("R8 user saved reads current", st_saved_o, 32'h0022_0044);
    st_we = 1'b1; st_saved = 1'b1; st_mask = 4'b1111; st_wdata = 32'h1234_5678;
    tick();
    st_we = 1'b0;
    check("R8 user saved write leaves current", st_cur_o, 32'h0022_0044);
    mode_i = 5'd19; tick();
    check("R8 user saved write ignored", st_saved_o, 32'hCAFE_AB0D);
    mode_i = 5'd16; tick();
    st_we = 1'b1; st_saved = 1'b0; st_mask = 4'b1111; st_wdata = 32'hFFFF_FFFF;
    tick();
    st_we = 1'b0;
    check("R10 user current write flags only", st_cur_o, 32'hFF22_0044);

    // R1 decode table
    for (int j = 0; j < NM; j++) begin
      mode_i = MODES[j];
      tick();
      check($sformatf("R1 bank for mode %0d", MODES[j]), 32'(bank_o), 32'(BANKS[j]));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule